// File: doc/BRIEF.md
# Multithreaded Commit Slot Thread Picker

This block decides, for each commit slot of a multithreaded out-of-order core, which hardware thread may retire its oldest in-flight instruction. For every thread it takes a three-bit status code, a flag that says the head instruction is ready, a flag that says the thread's reorder buffer is empty, and the sequence number of the head instruction. A policy input selects between two schemes. In the rotating scheme, threads are kept in a priority list and each grant sends the winner to the back of that list. In the age-based scheme, the thread whose head instruction is oldest wins.

Several commit slots are resolved in one cycle. Slot 0 is resolved first, and each later slot sees the priority list as the earlier grants of the same cycle left it. The list register is written once, at the clock edge, with the result after the last slot. Each slot has a request input and returns a valid bit and a thread index. The slot outputs are combinational, so the block adds no cycles between the per-thread flags and the grant. The reorder buffer and the retirement of instructions belong to the surrounding pipeline.

Top module: `smt_commit_picker`

## Requirements
- R1: Thread status codes are 0 idle, 1 running, 2 squashing, 3 trap waiting, 4 fetch-trap waiting, and 5 to 7 unused. A thread is eligible only when its status is 0, 1 or 4 and its `head_ready` bit is 1. A thread with any other status is never granted.
- R2: With `policy_sel` = 0 (rotating), a requested slot grants the first eligible thread found by scanning the priority list from the front. After the grant, the winner moves to the back of the list and the other threads keep their relative order.
- R3: After reset, the priority list holds the thread indices in ascending order, with thread 0 at the front.
- R4: With `policy_sel` = 1 (age-based), a thread must also have `rob_empty` = 0. Among the eligible threads, the one with the smallest `head_seq` (compared unsigned) is granted.
- R5: In the age-based scheme, a tie on `head_seq` goes to the lowest thread index.
- R6: `policy_sel` = 2 behaves exactly like the age-based scheme, and `policy_sel` = 3 behaves exactly like the rotating scheme.
- R7: When the block is built for a single thread, a requested slot grants thread 0 whenever its status is 0, 1 or 4. The policy, the ready flag and the empty flag are not examined.
- R8: When no thread is eligible, a requested slot drives `slot_valid` low and the priority list does not change.
- R9: Slots are resolved in ascending order within one cycle. Each slot sees the priority list already updated by the grants of lower slots in that cycle, so the same thread is granted again only if no other thread is eligible.
- R10: A slot whose `slot_req` bit is 0 drives `slot_valid` low and has no effect on the priority list.
- R11: Grants made under the age-based scheme leave the priority list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | 0 or 3 selects rotating, 1 or 2 selects age-based |
| slot_req | input | SLOTS | One request bit per commit slot |
| thr_status | input | NUM_THR*3 | Status code of each thread, thread i at bits [3i+2:3i] |
| head_ready | input | NUM_THR | Head instruction of the thread is ready to retire |
| rob_empty | input | NUM_THR | Reorder buffer of the thread holds nothing |
| head_seq | input | NUM_THR*SEQ_W | Head sequence number of each thread, thread i at bits [SEQ_W*(i+1)-1:SEQ_W*i] |
| slot_valid | output | SLOTS | The slot has a granted thread |
| slot_thread | output | SLOTS*IDXW | Granted thread index per slot, slot s at bits [IDXW*(s+1)-1:IDXW*s] |

## Verification
The assertions assume that the per-thread inputs and `policy_sel` stay steady between the edges at which they are sampled. They also assume that sequence numbers are unsigned and do not wrap within one comparison window, so the smallest value really is the oldest. The bench changes every input only on the falling clock edge, and its head sequence numbers are drawn from a range well below the wrap point. It drives all eight status codes, including the unused ones, so the eligibility check is exercised outside the encoded states as well.

// File: rtl/smt_commit_picker.sv
module smt_commit_picker #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  parameter int SLOTS   = 2,
  localparam int IDXW   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               policy_sel,
  input  logic [SLOTS-1:0]         slot_req,
  input  logic [NUM_THR*3-1:0]     thr_status,
  input  logic [NUM_THR-1:0]       head_ready,
  input  logic [NUM_THR-1:0]       rob_empty,
  input  logic [NUM_THR*SEQ_W-1:0] head_seq,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [SLOTS*IDXW-1:0]    slot_thread
);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_RUN   = 3'd1;
  localparam logic [2:0] ST_FTRAP = 3'd4;

  logic [NUM_THR-1:0] st_ok;

  always_comb begin
    for (int i = 0; i < NUM_THR; i++) begin
      st_ok[i] = (thr_status[i*3 +: 3] == ST_IDLE) ||
                 (thr_status[i*3 +: 3] == ST_RUN)  ||
                 (thr_status[i*3 +: 3] == ST_FTRAP);
    end
  end

  generate
    if (NUM_THR == 1) begin : g_single
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_valid[s]                = slot_req[s] & st_ok[0];
        assign slot_thread[s*IDXW +: IDXW]  = '0;
      end
    end else begin : g_multi
      logic [NUM_THR-1:0]      rr_elig, age_elig;
      logic                    use_age;
      logic                    age_hit;
      logic [IDXW-1:0]         age_tid;
      logic [SEQ_W-1:0]        age_seq;
      logic [IDXW-1:0]         ord_q [NUM_THR];
      logic [IDXW-1:0]         ord_c [SLOTS+1][NUM_THR];
      logic [SLOTS-1:0]        gnt_v;
      logic [IDXW-1:0]         gnt_t [SLOTS];
      logic [NUM_THR*IDXW-1:0] ord_flat;
      logic [NUM_THR-1:0]      ord_pres;

      assign rr_elig  = st_ok & head_ready;
      assign age_elig = rr_elig & ~rob_empty;
      assign use_age  = (policy_sel == 2'd1) || (policy_sel == 2'd2);

      always_comb begin
        age_hit = 1'b0;
        age_tid = '0;
        age_seq = '0;
        for (int i = 0; i < NUM_THR; i++) begin
          if (age_elig[i] && (!age_hit || head_seq[i*SEQ_W +: SEQ_W] < age_seq)) begin
            age_hit = 1'b1;
            age_tid = IDXW'(i);
            age_seq = head_seq[i*SEQ_W +: SEQ_W];
          end
        end
      end

      always_comb begin
        int  pos;
        logic hit;
        for (int p = 0; p < NUM_THR; p++) ord_c[0][p] = ord_q[p];
        for (int s = 0; s < SLOTS; s++) begin
          for (int p = 0; p < NUM_THR; p++) ord_c[s+1][p] = ord_c[s][p];
          gnt_v[s] = 1'b0;
          gnt_t[s] = '0;
          hit = 1'b0;
          pos = 0;
          for (int p = 0; p < NUM_THR; p++) begin
            if (!hit && rr_elig[ord_c[s][p]]) begin
              hit = 1'b1;
              pos = p;
            end
          end
          if (use_age) begin
            gnt_v[s] = slot_req[s] & age_hit;
            gnt_t[s] = age_tid;
          end else if (slot_req[s] && hit) begin
            gnt_v[s] = 1'b1;
            gnt_t[s] = ord_c[s][pos];
            for (int p = 0; p < NUM_THR-1; p++) begin
              if (p >= pos) ord_c[s+1][p] = ord_c[s][p+1];
            end
            ord_c[s+1][NUM_THR-1] = ord_c[s][pos];
          end
        end
      end

      always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_THR; p++) begin
          if (!rst_n) ord_q[p] <= IDXW'(p);
          else        ord_q[p] <= ord_c[SLOTS][p];
        end
      end

      assign slot_valid = gnt_v;
      for (genvar s = 0; s < SLOTS; s++) begin : g_out
        assign slot_thread[s*IDXW +: IDXW] = gnt_t[s];
      end

      always_comb begin
        ord_pres = '0;
        for (int p = 0; p < NUM_THR; p++) begin
          ord_flat[p*IDXW +: IDXW] = ord_q[p];
          ord_pres[ord_q[p]] = 1'b1;
        end
      end

      assert_list_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ord_pres) == NUM_THR);

      assert_age_keeps_list_R11: assert property (@(posedge clk) disable iff (!rst_n)
        use_age |=> $stable(ord_flat));

      assert_no_grant_keeps_list_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == '0) |=> $stable(ord_flat));

      for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
          slot_valid[s] |-> (st_ok[slot_thread[s*IDXW +: IDXW]] &&
                             head_ready[slot_thread[s*IDXW +: IDXW]]));
        assert_idle_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
          !slot_req[s] |-> !slot_valid[s]);
      end

      always_ff @(posedge clk) begin
        if (rst_n && use_age) begin
          for (int s = 0; s < SLOTS; s++) begin
            for (int j = 0; j < NUM_THR; j++) begin
              if (slot_valid[s] && age_elig[j])
                assert_oldest_wins_R4: assert (head_seq[slot_thread[s*IDXW +: IDXW]*SEQ_W +: SEQ_W]
                                               <= head_seq[j*SEQ_W +: SEQ_W]);
            end
          end
        end
      end
    end
  endgenerate

endmodule

// File: tb/smt_commit_picker_tb_top.sv
`timescale 1ns/1ps
module smt_commit_picker_tb_top;
  localparam int NT = 4;
  localparam int SW = 16;
  localparam int NS = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]     pol = 2'd0;
  logic [NS-1:0]  req = '0;
  logic [NT*3-1:0] st = '0;
  logic [NT-1:0]  rdy = '0;
  logic [NT-1:0]  emp = '0;
  logic [NT*SW-1:0] seq = '0;
  logic [NS-1:0]  vld;
  logic [NS*IW-1:0] tid;

  logic [2:0]     st1 = '0;
  logic           rdy1 = 1'b0;
  logic           emp1 = 1'b0;
  logic [SW-1:0]  seq1 = '0;
  logic [NS-1:0]  vld1;
  logic [NS-1:0]  tid1;

  always #5 clk = ~clk;

  smt_commit_picker #(.NUM_THR(NT), .SEQ_W(SW), .SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .slot_req(req),
    .thr_status(st), .head_ready(rdy), .rob_empty(emp), .head_seq(seq),
    .slot_valid(vld), .slot_thread(tid));

  smt_commit_picker #(.NUM_THR(1), .SEQ_W(SW), .SLOTS(NS)) dut1_i (
    .clk(clk), .rst_n(rst_n), .policy_sel(pol), .slot_req(req),
    .thr_status(st1), .head_ready(rdy1), .rob_empty(emp1), .head_seq(seq1),
    .slot_valid(vld1), .slot_thread(tid1));

  typedef struct {
    string tag;
    int    unit_sel;
    int    slot;
    bit    ev;
    int    et;
  } exp_t;

  exp_t sbq[$];
  int   mdl_ord[NT];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  event sample_ev;

  function automatic bit code_ok(logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd4);
  endfunction

  task automatic apply(string tag, logic [1:0] p, logic [NS-1:0] r, logic [NT*3-1:0] s,
                       logic [NT-1:0] hr, logic [NT-1:0] e, logic [NT*SW-1:0] q);
    bit rel[NT];
    bit oel[NT];
    bit found;
    int best;
    exp_t it;
    @(negedge clk);
    pol = p; req = r; st = s; rdy = hr; emp = e; seq = q;
    st1 = s[2:0]; rdy1 = ~hr[0]; emp1 = ~e[0]; seq1 = q[SW-1:0];
    for (int i = 0; i < NT; i++) begin
      rel[i] = code_ok(s[i*3 +: 3]) && hr[i];
      oel[i] = rel[i] && !e[i];
    end
    found = 1'b0;
    best = 0;
    for (int i = 0; i < NT; i++)
      if (oel[i] && (!found || q[i*SW +: SW] < q[best*SW +: SW])) begin
        found = 1'b1;
        best = i;
      end
    for (int k = 0; k < NS; k++) begin
      it.tag = tag; it.unit_sel = 0; it.slot = k; it.ev = 1'b0; it.et = 0;
      if (p == 2'd1 || p == 2'd2) begin
        it.ev = r[k] && found;
        it.et = best;
      end else if (r[k]) begin
        for (int pp = 0; pp < NT; pp++)
          if (!it.ev && rel[mdl_ord[pp]]) begin
            it.ev = 1'b1;
            it.et = mdl_ord[pp];
            for (int m = pp; m < NT-1; m++) mdl_ord[m] = mdl_ord[m+1];
            mdl_ord[NT-1] = it.et;
          end
      end
      sbq.push_back(it);
      it.tag = "R7 single thread"; it.unit_sel = 1;
      it.ev = r[k] && code_ok(s[2:0]); it.et = 0;
      sbq.push_back(it);
    end
    -> sample_ev;
    @(posedge clk);
  endtask

  initial begin : monitor
    exp_t it;
    bit av;
    int at;
    forever begin
      @(sample_ev);
      #1;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        if (it.unit_sel == 0) begin
          av = vld[it.slot];
          at = int'(tid[it.slot*IW +: IW]);
        end else begin
          av = vld1[it.slot];
          at = int'(tid1[it.slot]);
        end
        checks++;
        if (av !== it.ev || (it.ev && at != it.et)) begin
          errors++;
          $display("FAIL %s unit %0d slot %0d: valid %0b thread %0d, expected valid %0b thread %0d",
                   it.tag, it.unit_sel, it.slot, av, at, it.ev, it.et);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [NT*3-1:0] ALL_RUN = {3'd1, 3'd1, 3'd1, 3'd1};

  initial begin
    for (int i = 0; i < NT; i++) mdl_ord[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    apply("R10 no request after reset", 2'd0, 2'b00, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R3 ascending after reset", 2'd0, 2'b11, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R2 first eligible from front", 2'd0, 2'b01, ALL_RUN, 4'b1010, 4'h0, '0);
    apply("R1 status filter", 2'd0, 2'b11, {3'd4, 3'd5, 3'd3, 3'd2}, 4'hF, 4'h0, '0);
    apply("R1 idle status eligible", 2'd0, 2'b11, {3'd7, 3'd0, 3'd6, 3'd2}, 4'hF, 4'h0, '0);
    apply("R8 nothing eligible", 2'd0, 2'b11, ALL_RUN, 4'h0, 4'h0, '0);
    apply("R9 slots rotate in one cycle", 2'd0, 2'b11, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R10 only upper slot requested", 2'd0, 2'b10, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R4 smallest sequence", 2'd1, 2'b11, ALL_RUN, 4'hF, 4'h0,
          {16'd25, 16'd30, 16'd12, 16'd40});
    apply("R4 empty buffer excluded", 2'd1, 2'b11, ALL_RUN, 4'hF, 4'b0010,
          {16'd25, 16'd30, 16'd12, 16'd40});
    apply("R5 tie to lower index", 2'd1, 2'b01, ALL_RUN, 4'hF, 4'h0,
          {16'd7, 16'd7, 16'd90, 16'd50});
    apply("R6 policy 2 acts age-based", 2'd2, 2'b11, ALL_RUN, 4'hF, 4'h0,
          {16'd25, 16'd30, 16'd12, 16'd40});
    apply("R8 age-based all empty", 2'd1, 2'b11, ALL_RUN, 4'hF, 4'hF,
          {16'd1, 16'd2, 16'd3, 16'd4});
    apply("R11 list kept through age-based", 2'd0, 2'b11, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R6 policy 3 acts rotating", 2'd3, 2'b11, ALL_RUN, 4'hF, 4'h0, '0);
    apply("R7 ready ignored", 2'd1, 2'b11, {3'd1, 3'd1, 3'd1, 3'd4}, 4'h0, 4'hF, '0);

    for (int n = 0; n < 400; n++) begin
      logic [NT*3-1:0] rs;
      logic [NT*SW-1:0] rq;
      for (int i = 0; i < NT; i++) begin
        rs[i*3 +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd1;
        rq[i*SW +: SW] = SW'($urandom_range(0, 31));
      end
      apply("R9 mixed traffic", 2'($urandom_range(0, 3)), NS'($urandom_range(0, 3)), rs,
            NT'($urandom_range(0, 15)), NT'($urandom_range(0, 15)), rq);
    end

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule